// File: doc/BRIEF.md
# Soft Reset and Clock-Gate Controller

This block owns the reset and clock enable of one peripheral. Software drives it through a 32-bit control word with three write strobes: a plain load, a SET that ORs in the ones of the write data, and a CLR that removes them. Because of SET and CLR, software never needs a read-modify-write to change one bit.

Two software bits drive a small sequencer. Setting the soft-reset bit starts an internal reset pulse of a fixed, parameterised length. When the pulse ends, hardware sets the clock-gate bit, and software polls for it. While the reset bit stays set, hardware holds the gate set. To bring the peripheral back, software clears soft-reset first and then clears clock-gate. A read-only status bit reports the gated state once the enable has actually changed. The low 28 bits are plain configuration storage that is passed to the owned logic.

Top module: `srst_cg_ctrl`

## Requirements
- R1: After hardware reset, every read-data bit is 0, the peripheral reset output is 0 and the clock enable output is 1.
- R2: A plain write loads bit 31 (soft reset), bit 30 (clock gate) and bits 27:0 (configuration) from the write data. Bits 29 (gated status) and 28 (reset busy) are read-only, and written values for them have no effect.
- R3: A SET write ORs the write data into the writable bits. A CLR write clears every writable bit that is 1 in the write data. The result is readable on the cycle after the write edge.
- R4: When several strobes are active in one cycle they apply in the order plain, then SET, then CLR, so CLR wins on a bit that SET also touches.
- R5: One cycle after soft reset reads 1, the peripheral reset output and the busy bit go to 1. After RST_CYCLES cycles of busy, hardware sets the clock-gate bit and busy returns to 0.
- R6: While the reset sequence holds the block after the pulse, a CLR of the clock-gate bit has no effect, and the peripheral reset output stays 1.
- R7: After the pulse, clearing soft reset releases the peripheral reset output one cycle later. The clock-gate bit stays 1 until software clears it.
- R8: The gated status bit follows the clock-gate bit one cycle later, and the clock enable output is its inverse. This applies whether the gate was set by software or by hardware.
- R9: Clearing soft reset while the pulse is running does not shorten the pulse. The gate is still set at its end, and the reset output drops one cycle after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset, synchronous |
| wrPlain | input | 1 | Load the writable bits from wrData |
| wrSet | input | 1 | OR wrData into the writable bits |
| wrClr | input | 1 | Clear the writable bits that are set in wrData |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Control word and status |
| periphRst | output | 1 | Synchronous reset to the owned logic |
| periphClkEn | output | 1 | Clock enable to the owned logic |
| cfgOut | output | 28 | Configuration bits 27:0 |

## Verification
On every cycle, the assertions check the SET and CLR effect on the configuration bits, CLR priority, entry into the pulse state, the gate being held while reset is held, the release of the reset output once soft reset is cleared, and the clock enable dropping after the gate rises. Only the bench scenarios show the exact pulse length, the reset state, the ignored writes to the read-only bits, the ignored early clear of the gate, and a pulse that runs to completion after soft reset is cleared early. The bench sweeps many data patterns through each strobe combination and computes the expected words arithmetically.

// File: rtl/srst_cg_pkg.sv
package srst_cg_pkg;
  localparam int CTRL_W   = 32;
  localparam int SOFT_BIT = 31;
  localparam int GATE_BIT = 30;
  localparam int STS_BIT  = 29;
  localparam int BUSY_BIT = 28;
  localparam int CFG_W    = 28;
  localparam logic [CTRL_W-1:0] SW_MASK = 32'hCFFF_FFFF;

  typedef struct packed {
    logic setGate;
    logic holdGate;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_PULSE = 2'd1,
    ST_HOLD  = 2'd2
  } seqState_t;
endpackage

// File: rtl/srst_cg_seq.sv
module srst_cg_seq
  import srst_cg_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         softRst,
  output ctrlStrobes_t strobes,
  output logic         periphRst,
  output logic         busy
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  seqState_t stateQ;
  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_RUN;
      cntQ   <= '0;
    end else begin
      unique case (stateQ)
        ST_RUN: if (softRst) begin
          stateQ <= ST_PULSE;
          cntQ   <= CNT_W'(RST_CYCLES - 1);
        end
        ST_PULSE: if (cntQ == '0) stateQ <= ST_HOLD;
                  else cntQ <= cntQ - 1'b1;
        ST_HOLD: if (!softRst) stateQ <= ST_RUN;
        default: stateQ <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    strobes.setGate  = (stateQ == ST_PULSE) && (cntQ == '0);
    strobes.holdGate = (stateQ == ST_HOLD);
    periphRst        = (stateQ != ST_RUN);
    busy             = (stateQ == ST_PULSE);
  end

  // R5
  pulse_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN && softRst) |=> (stateQ == ST_PULSE));
endmodule

// File: rtl/srst_cg_regs.sv
module srst_cg_regs
  import srst_cg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrPlain,
  input  logic              wrSet,
  input  logic              wrClr,
  input  logic [CTRL_W-1:0] wrData,
  input  ctrlStrobes_t      strobes,
  input  logic              busy,
  output logic [CTRL_W-1:0] rdData,
  output logic              softRst,
  output logic              gateOn,
  output logic              clkEn
);
  logic [CTRL_W-1:0] swQ, swNxt, maskedData;
  logic gatedQ;

  always_comb begin
    maskedData = wrData & SW_MASK;
    swNxt = swQ;
    if (wrPlain) swNxt = maskedData;
    if (wrSet)   swNxt = swNxt | maskedData;
    if (wrClr)   swNxt = swNxt & ~maskedData;
    if (strobes.setGate || strobes.holdGate) swNxt[GATE_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swQ    <= '0;
      gatedQ <= 1'b0;
    end else begin
      swQ    <= swNxt;
      gatedQ <= swQ[GATE_BIT];
    end
  end

  always_comb begin
    rdData           = swQ;
    rdData[STS_BIT]  = gatedQ;
    rdData[BUSY_BIT] = busy;
    softRst          = swQ[SOFT_BIT];
    gateOn           = swQ[GATE_BIT];
    clkEn            = !gatedQ;
  end

  // R3
  set_cfg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrSet && !wrClr) |=> ((swQ[CFG_W-1:0] & $past(wrData[CFG_W-1:0])) == $past(wrData[CFG_W-1:0])));
  // R4
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrClr |=> ((swQ[CFG_W-1:0] & $past(wrData[CFG_W-1:0])) == '0));
endmodule

// File: rtl/srst_cg_ctrl.sv
module srst_cg_ctrl
  import srst_cg_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrPlain,
  input  logic              wrSet,
  input  logic              wrClr,
  input  logic [CTRL_W-1:0] wrData,
  output logic [CTRL_W-1:0] rdData,
  output logic              periphRst,
  output logic              periphClkEn,
  output logic [CFG_W-1:0]  cfgOut
);
  ctrlStrobes_t strobes;
  logic softRst, gateOn, busy;

  srst_cg_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
    .clk(clk), .rstN(rstN), .softRst(softRst), .strobes(strobes),
    .periphRst(periphRst), .busy(busy)
  );

  srst_cg_regs u_regs (
    .clk(clk), .rstN(rstN), .wrPlain(wrPlain), .wrSet(wrSet), .wrClr(wrClr),
    .wrData(wrData), .strobes(strobes), .busy(busy), .rdData(rdData),
    .softRst(softRst), .gateOn(gateOn), .clkEn(periphClkEn)
  );

  assign cfgOut = rdData[CFG_W-1:0];

  // R6
  gate_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (periphRst && !busy && softRst) |-> gateOn);
  // R7
  rst_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (periphRst && !busy && !softRst) |=> !periphRst);
  // R8
  clk_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOn) |=> !periphClkEn);
endmodule

// File: tb/test_srst_cg_ctrl.sv
module test_srst_cg_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RST_CYCLES = 16;
  localparam logic [31:0] CFG_MASK = 32'h0FFF_FFFF;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrPlain = 1'b0, wrSet = 1'b0, wrClr = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic periphRst, periphClkEn;
  logic [27:0] cfgOut;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  srst_cg_ctrl #(.RST_CYCLES(RST_CYCLES)) i_srst_cg_ctrl (
    .clk(clk), .rstN(rstN), .wrPlain(wrPlain), .wrSet(wrSet), .wrClr(wrClr),
    .wrData(wrData), .rdData(rdData), .periphRst(periphRst),
    .periphClkEn(periphClkEn), .cfgOut(cfgOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(bit p, bit s, bit c, logic [31:0] d);
    wrPlain = p; wrSet = s; wrClr = c; wrData = d;
    @(negedge clk);
    wrPlain = 1'b0; wrSet = 1'b0; wrClr = 1'b0; wrData = '0;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] model, d1, d2, d3;
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 rd", rdData, 32'h0);
    check("R1 rst", {31'b0, periphRst}, 32'h0);
    check("R1 en", {31'b0, periphClkEn}, 32'h1);

    // R2 read-only bits ignore plain and SET writes
    doWrite(1, 0, 0, 32'h3000_0000);
    check("R2 ro plain", rdData, 32'h0);
    doWrite(0, 1, 0, 32'h3000_0005);
    check("R2 ro set", rdData, 32'h5);

    model = 32'h5;
    for (int i = 0; i < 64; i++) begin
      d1 = (32'h0123_4567 * (i + 1)) ^ {i[7:0], i[7:0], i[7:0], i[7:0]};
      d2 = (d1 << (i % 7)) ^ 32'h00A5_5A00;
      d3 = ~(d1 >> (i % 5)) ^ (32'h1 << (i % 28));
      d1 &= CFG_MASK; d2 &= CFG_MASK; d3 &= CFG_MASK;
      // R2 plain load
      doWrite(1, 0, 0, d1 | 32'h3000_0000);
      model = d1;
      check("R2 plain", rdData, model);
      check("R2 cfgOut", {4'b0, cfgOut}, model);
      // R3 SET then CLR
      doWrite(0, 1, 0, d2);
      model |= d2;
      check("R3 set", rdData, model);
      doWrite(0, 0, 1, d3);
      model &= ~d3;
      check("R3 clr", rdData, model);
      // R4 combined strobes, CLR last
      doWrite(i[0], 1, 1, d2);
      model = (i[0] ? d2 : model) & ~d2;
      check("R4 prio", rdData, model);
      doWrite(1, 1, 0, d3);
      model = d3;
      check("R4 plain+set", rdData, model);
    end
    doWrite(1, 0, 0, 32'h0);

    // R8 software gate without reset
    doWrite(0, 1, 0, 32'h4000_0000);
    check("R8 gate bit", rdData, 32'h4000_0000);
    check("R8 en lag", {31'b0, periphClkEn}, 32'h1);
    tick(1);
    check("R8 sts", rdData, 32'h6000_0000);
    check("R8 en off", {31'b0, periphClkEn}, 32'h0);
    check("R8 no rst", {31'b0, periphRst}, 32'h0);
    doWrite(0, 0, 1, 32'h4000_0000);
    check("R8 clr", rdData, 32'h2000_0000);
    tick(1);
    check("R8 en on", {31'b0, periphClkEn}, 32'h1);

    // R5 reset pulse
    doWrite(0, 1, 0, 32'h8000_0000);
    check("R5 pre", {31'b0, periphRst}, 32'h0);
    tick(1);
    check("R5 rst", {31'b0, periphRst}, 32'h1);
    check("R5 busy", rdData, 32'h9000_0000);
    tick(RST_CYCLES - 1);
    check("R5 last busy", rdData, 32'h9000_0000);
    tick(1);
    check("R5 gate set", rdData, 32'hC000_0000);
    tick(1);
    check("R5 gated", rdData, 32'hE000_0000);
    check("R8 hw gate en", {31'b0, periphClkEn}, 32'h0);
    // R6 clearing gate first is ignored
    doWrite(0, 0, 1, 32'h4000_0000);
    check("R6 gate held", rdData, 32'hE000_0000);
    check("R6 rst held", {31'b0, periphRst}, 32'h1);
    // R7 release
    doWrite(0, 0, 1, 32'h8000_0000);
    check("R7 soft clr", rdData, 32'h6000_0000);
    tick(1);
    check("R7 released", {31'b0, periphRst}, 32'h0);
    check("R7 gate kept", rdData, 32'h6000_0000);
    doWrite(0, 0, 1, 32'h4000_0000);
    check("R7 gate clr", rdData, 32'h2000_0000);
    tick(1);
    check("R7 running", {rdData[31:1], periphClkEn}, 32'h1);

    // R9 early clear of soft reset
    doWrite(0, 1, 0, 32'h8000_0000);
    doWrite(0, 0, 1, 32'h8000_0000);
    check("R9 busy", rdData, 32'h1000_0000);
    check("R9 rst", {31'b0, periphRst}, 32'h1);
    tick(RST_CYCLES - 1);
    check("R9 still busy", rdData, 32'h1000_0000);
    tick(1);
    check("R9 gate set", rdData, 32'h4000_0000);
    check("R9 rst end", {31'b0, periphRst}, 32'h1);
    tick(1);
    check("R9 rst drop", {31'b0, periphRst}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule